// File: doc/BRIEF.md
# Clock-Pulse Wiper Step Engine

This block runs the step session of a two-channel serial-controlled volume potentiometer. The host first sends a step command, which is decoded and acknowledged elsewhere. After that, each clock pulse on the two-wire bus moves the selected tap counters by one position. The data line level during the pulse gives the direction: high moves toward the top tap, low moves toward the bottom. No bytes are framed and no acknowledge is given while the session is open. The session ends when the host sends a stop or a new start condition.

The block does not watch raw bus pins. It takes synchronized levels and one-cycle edge pulses of both bus lines, plus a one-cycle `sess_go` strobe. That strobe arrives together with the channel selects from the decoded command. The counters start at tap 0, the mute position, and they saturate at both ends. A one-cycle strobe marks every step that is committed.

Top module: `wstep_engine`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every tap counter reads 0 and `step_stb` is low.
- R2: In an open session, an SCL pulse taken while SDA is high (`sda_lvl`=1 at the `scl_rise` cycle) adds one to each selected counter.
- R3: In an open session, an SCL pulse taken while SDA is low subtracts one from each selected counter.
- R4: `chan_sel_in` bit 0 selects the left counter (`wiper_pos[TAP_W-1:0]`) and bit 1 selects the right counter (the next TAP_W bits). With both bits set, both counters step. With neither bit set, no counter moves, but `step_stb` still pulses.
- R5: A counter at 31 does not move on an up step, and a counter at 0 does not move on a down step. `step_stb` still pulses in both cases.
- R6: SCL pulses taken while no session is open change no counter and give no `step_stb`.
- R7: A rising SDA edge while SCL is high (stop) closes the session. The pulse that carried it produces no step.
- R8: A falling SDA edge while SCL is high (start) also closes the session and cancels the step of that pulse.
- R9: The selects are captured on `sess_go`. Later changes on `chan_sel_in` have no effect until the next `sess_go`.
- R10: A step becomes visible in the cycle after the `scl_fall` pulse. The counters and a one-cycle `step_stb` change together in that cycle and never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sess_go | input | 1 | One-cycle strobe: step command acknowledged, session opens |
| chan_sel_in | input | NUM_CH | Channel selects from the command (bit 0 left, bit 1 right) |
| scl_lvl | input | 1 | Synchronized SCL level |
| scl_rise | input | 1 | One-cycle pulse on an SCL rising edge |
| scl_fall | input | 1 | One-cycle pulse on an SCL falling edge |
| sda_lvl | input | 1 | Synchronized SDA level |
| sda_rise | input | 1 | One-cycle pulse on an SDA rising edge |
| sda_fall | input | 1 | One-cycle pulse on an SDA falling edge |
| wiper_pos | output | NUM_CH*TAP_W | Tap counters, left in the low field |
| step_stb | output | 1 | One-cycle strobe for each committed step |

## Verification
The assertions assume well-formed inputs. Each edge pulse lasts a single cycle and matches a real change of the level it belongs to. SCL stays high for at least one cycle between its rise and fall pulses. No SDA edge coincides with an SCL edge or with `sess_go`. The stimulus tasks move one line per cycle from the falling clock edge, so every pulse lands on its own cycle. SDA changes only while SCL is low, except on purpose to form a start or a stop.

// File: rtl/wstep_pkg.sv
package wstep_pkg;

    typedef enum logic {
        DIR_DN = 1'b0,
        DIR_UP = 1'b1
    } step_dir_e;

    typedef struct packed {
        logic      live;   // session open
        logic      armed;  // SCL is high inside a session, step pending
        step_dir_e dir;    // direction captured at SCL rise
    } sess_st_t;

    // Saturating one-tap move between 0 and top
    function automatic int unsigned tap_next(int unsigned cur, int unsigned top, step_dir_e d);
        if (d == DIR_UP) begin
            return (cur >= top) ? top : cur + 1;
        end
        return (cur == 0) ? 0 : cur - 1;
    endfunction

endpackage

// File: rtl/wstep_bus_watch.sv
module wstep_bus_watch
    import wstep_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sess_go,
    input  logic [NUM_CH-1:0] chan_sel_in,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    output logic              commit,
    output step_dir_e         commit_dir,
    output logic [NUM_CH-1:0] sel_q
);

    sess_st_t st;
    logic     bus_cond;

    // Any SDA movement while SCL is high is a start or a stop
    assign bus_cond = scl_lvl & (sda_rise | sda_fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '{live: 1'b0, armed: 1'b0, dir: DIR_DN};
            sel_q <= '0;
        end else if (bus_cond) begin
            st.live  <= 1'b0;
            st.armed <= 1'b0;
        end else if (sess_go) begin
            st.live  <= 1'b1;
            st.armed <= 1'b0;
            sel_q    <= chan_sel_in;
        end else if (scl_rise && st.live) begin
            st.armed <= 1'b1;
            st.dir   <= step_dir_e'(sda_lvl);
        end else if (scl_fall) begin
            st.armed <= 1'b0;
        end
    end

    assign commit     = scl_fall & st.armed;
    assign commit_dir = st.dir;

endmodule

// File: rtl/wstep_tap_ctr.sv
module wstep_tap_ctr
    import wstep_pkg::*;
#(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  step_dir_e        dir,
    output logic [TAP_W-1:0] pos
);

    localparam int unsigned TOP = (1 << TAP_W) - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (en) begin
            pos <= TAP_W'(tap_next(32'(pos), TOP, dir));
        end
    end

endmodule

// File: rtl/wstep_engine.sv
module wstep_engine
    import wstep_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int TAP_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sess_go,
    input  logic [NUM_CH-1:0]       chan_sel_in,
    input  logic                    scl_lvl,
    input  logic                    scl_rise,
    input  logic                    scl_fall,
    input  logic                    sda_lvl,
    input  logic                    sda_rise,
    input  logic                    sda_fall,
    output logic [NUM_CH*TAP_W-1:0] wiper_pos,
    output logic                    step_stb
);

    logic              commit;
    step_dir_e         commit_dir;
    logic [NUM_CH-1:0] sel_q;

    wstep_bus_watch #(.NUM_CH(NUM_CH)) watch_i (
        .clk        (clk),
        .rst        (rst),
        .sess_go    (sess_go),
        .chan_sel_in(chan_sel_in),
        .scl_lvl    (scl_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_lvl    (sda_lvl),
        .sda_rise   (sda_rise),
        .sda_fall   (sda_fall),
        .commit     (commit),
        .commit_dir (commit_dir),
        .sel_q      (sel_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        wstep_tap_ctr #(.TAP_W(TAP_W)) ctr_i (
            .clk(clk),
            .rst(rst),
            .en (commit & sel_q[c]),
            .dir(commit_dir),
            .pos(wiper_pos[c*TAP_W +: TAP_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_stb <= 1'b0;
        end else begin
            step_stb <= commit;
        end
    end

endmodule

// File: rtl/wstep_engine_chk.sv
module wstep_engine_chk #(
    parameter int NUM_CH = 2,
    parameter int TAP_W  = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    sess_go,
    input logic                    scl_lvl,
    input logic                    scl_fall,
    input logic                    sda_rise,
    input logic                    sda_fall,
    input logic [NUM_CH*TAP_W-1:0] wiper_pos,
    input logic                    step_stb
);

    // Independent view of whether a session is open, from the ports only
    logic chk_live;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_live <= 1'b0;
        end else if (scl_lvl && (sda_rise || sda_fall)) begin
            chk_live <= 1'b0;
        end else if (sess_go) begin
            chk_live <= 1'b1;
        end
    end

    a_r1_reset_mute: assert property (@(posedge clk)
        rst |=> (wiper_pos == '0 && !step_stb));

    a_r10_stb_after_fall: assert property (@(posedge clk) disable iff (rst)
        step_stb |-> $past(scl_fall));

    a_r10_stb_one_cycle: assert property (@(posedge clk) disable iff (rst)
        step_stb |=> !step_stb);

    a_r10_pos_only_on_stb: assert property (@(posedge clk) disable iff (rst)
        !step_stb |-> $stable(wiper_pos));

    a_r6_step_in_session: assert property (@(posedge clk) disable iff (rst)
        step_stb |-> chk_live);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R2 R3 R5: one tap at most per step, no wrap at either end
        a_r5_one_tap_no_wrap: assert property (@(posedge clk) disable iff (rst)
            step_stb |->
                ({1'b0, wiper_pos[c*TAP_W +: TAP_W]} == {1'b0, $past(wiper_pos[c*TAP_W +: TAP_W])} + 1'b1) ||
                ({1'b0, wiper_pos[c*TAP_W +: TAP_W]} + 1'b1 == {1'b0, $past(wiper_pos[c*TAP_W +: TAP_W])}) ||
                (wiper_pos[c*TAP_W +: TAP_W] == $past(wiper_pos[c*TAP_W +: TAP_W])));
    end

endmodule

bind wstep_engine wstep_engine_chk #(.NUM_CH(NUM_CH), .TAP_W(TAP_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .sess_go  (sess_go),
    .scl_lvl  (scl_lvl),
    .scl_fall (scl_fall),
    .sda_rise (sda_rise),
    .sda_fall (sda_fall),
    .wiper_pos(wiper_pos),
    .step_stb (step_stb)
);

// File: tb/wstep_engine_tb_top.sv
`timescale 1ns/1ps
module wstep_engine_tb_top;

    localparam int NUM_CH = 2;
    localparam int TAP_W  = 5;
    localparam int TOP    = 31;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sess_go = 1'b0;
    logic [NUM_CH-1:0] chan_sel_in = '0;
    logic scl_lvl = 1'b1, scl_rise = 1'b0, scl_fall = 1'b0;
    logic sda_lvl = 1'b1, sda_rise = 1'b0, sda_fall = 1'b0;
    logic [NUM_CH*TAP_W-1:0] wiper_pos;
    logic step_stb;

    always #2.5 clk = ~clk;

    wstep_engine #(.NUM_CH(NUM_CH), .TAP_W(TAP_W)) dut_i (
        .clk(clk), .rst(rst), .sess_go(sess_go), .chan_sel_in(chan_sel_in),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .wiper_pos(wiper_pos), .step_stb(step_stb)
    );

    // Behavioural reference model
    int    m_pos[NUM_CH];
    int    m_sel;
    bit    m_sess;
    bit    exp_stb;
    int    total, bad;
    bit    done;
    string cur_req = "R1";

    function automatic logic [NUM_CH*TAP_W-1:0] exp_vec();
        logic [NUM_CH*TAP_W-1:0] v = '0;
        for (int c = 0; c < NUM_CH; c++) v[c*TAP_W +: TAP_W] = TAP_W'(m_pos[c]);
        return v;
    endfunction

    always @(posedge clk) begin
        #1;
        if (!done) begin
            total++;
            if (wiper_pos !== exp_vec() || step_stb !== exp_stb) begin
                bad++;
                $display("FAIL %s: pos=%h stb=%b expected pos=%h stb=%b",
                         cur_req, wiper_pos, step_stb, exp_vec(), exp_stb);
            end
        end
    end

    task automatic set_sda(input logic v);
        @(negedge clk);
        if (v != sda_lvl) begin
            sda_lvl = v;
            if (v) sda_rise = 1'b1; else sda_fall = 1'b1;
            @(negedge clk);
            sda_rise = 1'b0; sda_fall = 1'b0;
        end
    endtask

    task automatic scl_up();
        @(negedge clk); scl_lvl = 1'b1; scl_rise = 1'b1;
        @(negedge clk); scl_rise = 1'b0;
    endtask

    task automatic scl_dn();
        @(negedge clk); scl_lvl = 1'b0; scl_fall = 1'b1;
        @(negedge clk); scl_fall = 1'b0;
    endtask

    // One SCL pulse carrying direction d
    task automatic pulse(input logic d);
        if (scl_lvl) scl_dn();
        set_sda(d);
        scl_up();
        @(negedge clk); scl_lvl = 1'b0; scl_fall = 1'b1;
        @(posedge clk);
        if (m_sess) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (m_sel[c]) begin
                    if (d) m_pos[c] = (m_pos[c] < TOP) ? m_pos[c] + 1 : TOP;
                    else   m_pos[c] = (m_pos[c] > 0) ? m_pos[c] - 1 : 0;
                end
            end
            exp_stb = 1'b1;
        end
        @(negedge clk); scl_fall = 1'b0;
        @(posedge clk); exp_stb = 1'b0;
    endtask

    // Start condition, SCL low, then command-acknowledged strobe
    task automatic open_sess(input logic [NUM_CH-1:0] sel);
        if (!scl_lvl) begin set_sda(1'b1); scl_up(); end
        else set_sda(1'b1);
        set_sda(1'b0);
        m_sess = 1'b0;
        scl_dn();
        @(negedge clk); sess_go = 1'b1; chan_sel_in = sel;
        @(negedge clk); sess_go = 1'b0;
        m_sess = 1'b1; m_sel = int'(sel);
    endtask

    task automatic send_stop();
        if (scl_lvl) scl_dn();
        set_sda(1'b0);
        scl_up();
        set_sda(1'b1);
        m_sess = 1'b0;
    endtask

    task automatic send_restart();
        if (scl_lvl) scl_dn();
        set_sda(1'b1);
        scl_up();
        set_sda(1'b0);
        m_sess = 1'b0;
        scl_dn();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        for (int c = 0; c < NUM_CH; c++) m_pos[c] = 0;
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        cur_req = "R6_before_session";
        pulse(1'b1);

        cur_req = "R2_R4_both_up";
        open_sess(2'b11);
        repeat (3) pulse(1'b1);

        cur_req = "R3_both_down";
        pulse(1'b0);

        cur_req = "R7_stop";
        send_stop();
        cur_req = "R6_after_stop";
        pulse(1'b1);
        pulse(1'b0);

        cur_req = "R9_sel_latched";
        open_sess(2'b01);
        @(negedge clk); chan_sel_in = 2'b10;
        repeat (2) pulse(1'b1);

        cur_req = "R5_top_saturate";
        open_sess(2'b10);
        repeat (33) pulse(1'b1);

        cur_req = "R5_bottom_saturate";
        open_sess(2'b01);
        repeat (6) pulse(1'b0);

        cur_req = "R8_start_cancels";
        open_sess(2'b10);
        send_restart();
        cur_req = "R6_after_start";
        pulse(1'b0);

        cur_req = "R4_none_selected";
        open_sess(2'b00);
        pulse(1'b0);
        pulse(1'b1);

        cur_req = "R10_mixed";
        open_sess(2'b11);
        pulse(1'b0);
        pulse(1'b1);
        pulse(1'b0);
        send_stop();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule